// File: doc/BRIEF.md
# Daisy-Chain DAC Frame Master

This block is the host side of a serial link to a chain of identical 16-bit-word DACs that share one serial clock and one active-low frame strobe. One handshake hands it a flat vector holding one command word per device. The block drops the strobe, runs exactly 16 serial clock cycles per device, and sends every word MSB first. It then raises the strobe, so all devices in the chain latch their new words on the same edge.

All interface timing is counted in system-clock cycles and derived from the system clock frequency parameter. The cycle counts cover the strobe-to-first-edge setup, the serial clock high and low phases, the strobe release after the last edge, and the minimum strobe-high gap between frames. A programmable half-period divider sets the serial clock rate. The block never lets that rate exceed the limit for the active configuration: 50 MHz for a lone device, 10 MHz once two or more devices are chained. A package function builds a command word from a power mode and a 12-bit code.

Top module: `dac_chain_master`

## Requirements
- R1: After reset the serial clock and the frame strobe are high, serial data is 0, `in_ready` is 1, and `busy` and `done` are 0.
- R2: Every frame produces exactly 16·N_DEV falling serial clock edges while the strobe is low, and the strobe then returns high.
- R3: Bits are sent MSB first from the whole `in_words` vector, so the word in the top 16 bits goes out first; that slot is for the device farthest along the chain. The vector is captured when the handshake completes, and later changes to `in_words` do not alter the frame.
- R4: Serial data changes only when the serial clock rises, or when a frame is accepted. It holds steady for every cycle the serial clock is low, so it is stable on both sides of each falling edge.
- R5: The strobe falls while the serial clock is high. The first falling serial clock edge comes exactly SETUP_CYC system cycles later, with SETUP_CYC = ceil(4 ns · f_sys), and never less than 1.
- R6: Every high and low serial clock phase inside a frame lasts max(`cfg_half_div`, MIN_HALF) system cycles. MIN_HALF = ceil(f_sys / (2·f_max)), where f_max is 10 MHz when N_DEV > 1 and 50 MHz when N_DEV = 1. With the defaults, MIN_HALF is 5.
- R7: The strobe rises in the same cycle the serial clock returns high, one low phase after the last falling edge.
- R8: After the strobe rises, `in_ready` stays 0 for IDLE_CYC system cycles, with IDLE_CYC = ceil(20 ns · f_sys), which is 2 at 100 MHz. It is also 0 for the whole time the strobe is low.
- R9: `busy` is 1 exactly while the strobe is low. `done` is a one-cycle pulse in the cycle the strobe rises.
- R10: `dcm_pkg::fmt_word(mode, code)` returns {2'b00, mode, code}. Mode 00 means normal output; 01, 10 and 11 select power-down into 1 kΩ, 100 kΩ and high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | Requested serial clock half-period in system cycles, captured when a frame is accepted |
| in_valid | input | 1 | A set of words is offered |
| in_ready | output | 1 | The block can accept a set of words |
| in_words | input | 16·N_DEV | Command words; the top 16 bits go to the farthest device |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sync_n | output | 1 | Active-low frame strobe, idles high |
| dac_sdin | output | 1 | Serial data toward the first device |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the strobe rises |

## Verification
Some behaviours are checked by assertions on every cycle. These are the falling-edge count at each strobe release, data stability through low clock phases, the strobe falling only while the clock is high, the lower bound on low-phase length, the strobe and clock rising together, `in_ready` held off while the strobe is low, and `done` matching the strobe rise. Other behaviours only the directed scenarios can show: the exact bit order across device words, that the vector is captured at acceptance, the exact setup and gap lengths, and the clamping of slow, minimum and zero divider requests to the chained-mode floor.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } dcm_state_e;

  // Command word: two unused bits, power mode, 12-bit code.
  function automatic logic [WORD_W-1:0] fmt_word(input logic [1:0] mode,
                                                  input logic [11:0] code);
    return {2'b00, mode, code};
  endfunction

endpackage

// File: rtl/dcm_phase_timer.sv
module dcm_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  // A phase loaded with L lasts exactly L cycles; expire flags its last one.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == CNT_W'(1));

  assert_load_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

endmodule

// File: rtl/dcm_shifter.sv
module dcm_shifter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         ser_out
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_data;
    end else if (shift) begin
      sr_q <= {sr_q[W-2:0], 1'b0};
    end
  end

  assign ser_out = sr_q[W-1];

endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master
  import dcm_pkg::*;
#(
  parameter int N_DEV       = 3,
  parameter int SYS_CLK_MHZ = 100,
  parameter int DIV_W       = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DIV_W-1:0]        cfg_half_div,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [N_DEV*WORD_W-1:0] in_words,
  output logic                    dac_sclk,
  output logic                    dac_sync_n,
  output logic                    dac_sdin,
  output logic                    busy,
  output logic                    done
);

  localparam int TOTAL_BITS   = N_DEV * WORD_W;
  localparam int BIT_W        = $clog2(TOTAL_BITS + 1);
  localparam int MAX_SCLK_MHZ = (N_DEV > 1) ? 10 : 50;
  localparam int MIN_HALF_I   = (SYS_CLK_MHZ + 2*MAX_SCLK_MHZ - 1) / (2*MAX_SCLK_MHZ);
  localparam int SETUP_RAW    = (4 * SYS_CLK_MHZ + 999) / 1000;
  localparam int IDLE_RAW     = (20 * SYS_CLK_MHZ + 999) / 1000;
  localparam int SETUP_I      = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int IDLE_I       = (IDLE_RAW < 1) ? 1 : IDLE_RAW;

  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(MIN_HALF_I);
  localparam logic [DIV_W-1:0] SETUP_V  = DIV_W'(SETUP_I);
  localparam logic [DIV_W-1:0] IDLE_V   = DIV_W'(IDLE_I);
  localparam logic [BIT_W-1:0] TOTAL_V  = BIT_W'(TOTAL_BITS);

  dcm_state_e       state_q;
  logic [DIV_W-1:0] half_q, half_eff, tmr_val;
  logic [BIT_W-1:0] bits_q;
  logic             sclk_q, sync_q, ready_q, busy_q, done_q;
  logic             tmr_load, tmr_exp, sh_shift, accept, last_bit;

  assign accept   = in_valid && ready_q;
  assign last_bit = (bits_q == BIT_W'(1));
  assign half_eff = (cfg_half_div < MIN_HALF) ? MIN_HALF : cfg_half_div;

  dcm_phase_timer #(.CNT_W(DIV_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_exp)
  );

  dcm_shifter #(.W(TOTAL_BITS)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (in_words),
    .shift     (sh_shift),
    .ser_out   (dac_sdin)
  );

  // Phase timer and shifter control
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = half_q;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          tmr_val  = SETUP_V;
        end
      end
      ST_SETUP, ST_HIGH: begin
        if (tmr_exp) tmr_load = 1'b1;
      end
      ST_LOW: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (last_bit) tmr_val = IDLE_V;
          else          sh_shift = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Frame sequencer with registered pin outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      half_q  <= MIN_HALF;
      bits_q  <= '0;
      sclk_q  <= 1'b1;
      sync_q  <= 1'b1;
      ready_q <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_SETUP;
            half_q  <= half_eff;
            bits_q  <= TOTAL_V;
            sync_q  <= 1'b0;
            ready_q <= 1'b0;
            busy_q  <= 1'b1;
          end
        end
        ST_SETUP, ST_HIGH: begin
          if (tmr_exp) begin
            state_q <= ST_LOW;
            sclk_q  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tmr_exp) begin
            sclk_q <= 1'b1;
            if (last_bit) begin
              state_q <= ST_GAP;
              sync_q  <= 1'b1;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_HIGH;
              bits_q  <= bits_q - 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tmr_exp) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_sclk   = sclk_q;
  assign dac_sync_n = sync_q;
  assign in_ready   = ready_q;
  assign busy       = busy_q;
  assign done       = done_q;

  // ---------------- checks ----------------
  logic             sclk_prev_q;
  logic [BIT_W:0]   fall_cnt_q;
  logic [DIV_W:0]   low_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b1;
      fall_cnt_q  <= '0;
      low_run_q   <= '0;
    end else begin
      sclk_prev_q <= dac_sclk;
      if (dac_sync_n)                     fall_cnt_q <= '0;
      else if (sclk_prev_q && !dac_sclk)  fall_cnt_q <= fall_cnt_q + 1'b1;
      if (!dac_sclk) low_run_q <= low_run_q + 1'b1;
      else           low_run_q <= '0;
    end
  end

  assert_frame_falls_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sync_n) |-> (fall_cnt_q == {1'b0, TOTAL_V}));

  assert_data_stable_low_R4: assert property (@(posedge clk) disable iff (rst)
    !dac_sclk |-> $stable(dac_sdin));

  assert_sync_fall_sclk_high_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_sync_n) |-> dac_sclk);

  assert_low_phase_min_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sclk) |-> (low_run_q >= {1'b0, MIN_HALF}));

  assert_sync_rise_with_sclk_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sync_n) |-> $rose(dac_sclk));

  assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    !dac_sync_n |-> !in_ready);

  assert_done_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    done == $rose(dac_sync_n));

  assert_busy_tracks_sync_R9: assert property (@(posedge clk) disable iff (rst)
    busy == !dac_sync_n);

endmodule

// File: tb/test_dac_chain_master.sv
module test_dac_chain_master;
  import dcm_pkg::*;

  localparam int N     = 3;
  localparam int TOT   = N * 16;
  localparam int DIVW  = 8;
  localparam int MINH  = 5;
  localparam int SETUP = 1;
  localparam int IDLE  = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [DIVW-1:0] cfg_half_div = '0;
  logic            in_valid = 1'b0;
  logic [TOT-1:0]  in_words = '0;
  logic            in_ready, dac_sclk, dac_sync_n, dac_sdin, busy, done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dac_chain_master #(.N_DEV(N), .SYS_CLK_MHZ(100), .DIV_W(DIVW)) i_dac_chain_master (
    .clk          (clk),
    .rst          (rst),
    .cfg_half_div (cfg_half_div),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_words     (in_words),
    .dac_sclk     (dac_sclk),
    .dac_sync_n   (dac_sync_n),
    .dac_sdin     (dac_sdin),
    .busy         (busy),
    .done         (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // One frame: offer words, watch pins at negedges, check timing and data.
  task automatic run_frame(input logic [TOT-1:0] w, input logic [DIVW-1:0] half_cfg,
                           input int exp_half);
    int setup_run = 0, run = 0, falls = 0, bad_runs = 0, bad_stable = 0;
    int busy_bad = 0, rdy_bad = 0, hi = 0, guard = 0;
    bit seen_fall = 0;
    logic prev = 1'b1, low_val = 1'b0;
    logic [TOT-1:0] got = '0;
    cfg_half_div = half_cfg;
    in_words     = w;
    in_valid     = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_words = ~w;       // R3: must not disturb the captured frame
    while (dac_sync_n == 1'b0 && guard < 20000) begin
      guard++;
      if (!seen_fall) begin
        if (dac_sclk) setup_run++;
        else begin
          seen_fall = 1; run = 1; falls = 1;
          got = {got[TOT-2:0], dac_sdin}; low_val = dac_sdin;
        end
      end else if (dac_sclk != prev) begin
        if (run != exp_half) bad_runs++;
        run = 1;
        if (!dac_sclk) begin
          falls++;
          got = {got[TOT-2:0], dac_sdin}; low_val = dac_sdin;
        end
      end else begin
        run++;
        if (!dac_sclk && dac_sdin != low_val) bad_stable++;
      end
      if (busy !== 1'b1) busy_bad++;
      if (in_ready)      rdy_bad++;
      prev = dac_sclk;
      @(negedge clk);
    end
    chk(guard < 20000, "R2", "frame ended", 64'(guard), 64'(20000));
    chk(setup_run == SETUP, "R5", "setup cycles", 64'(setup_run), 64'(SETUP));
    chk(falls == TOT, "R2", "falling edges", 64'(falls), 64'(TOT));
    chk(got == w, "R3", "serial bits", 64'(got), 64'(w));
    chk(bad_runs == 0 && run == exp_half, "R6", "phase length", 64'(run), 64'(exp_half));
    chk(bad_stable == 0, "R4", "data moved while low", 64'(bad_stable), 64'(0));
    chk(dac_sclk == 1'b1, "R7", "sclk at sync rise", 64'(dac_sclk), 64'(1));
    chk(done == 1'b1, "R9", "done at sync rise", 64'(done), 64'(1));
    chk(busy_bad == 0 && busy == 1'b0, "R9", "busy tracks sync", 64'(busy_bad), 64'(0));
    chk(rdy_bad == 0, "R8", "ready during frame", 64'(rdy_bad), 64'(0));
    // strobe-high gap before ready returns
    hi = 1;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 64'(done), 64'(0));
    guard = 0;
    while (!in_ready && guard < 100) begin
      guard++;
      if (!dac_sync_n) rdy_bad++;
      hi++;
      @(negedge clk);
    end
    chk(hi == IDLE && rdy_bad == 0, "R8", "gap cycles before ready", 64'(hi), 64'(IDLE));
  endtask

  task automatic test_reset;
    chk(dac_sclk == 1'b1 && dac_sync_n == 1'b1, "R1", "idle pins",
        64'({dac_sclk, dac_sync_n}), 64'(3));
    chk(in_ready == 1'b1 && busy == 1'b0 && done == 1'b0 && dac_sdin == 1'b0, "R1",
        "ready/busy/done/sdin", 64'({in_ready, busy, done, dac_sdin}), 64'(8));
  endtask

  task automatic test_helper;
    chk(fmt_word(2'b00, 12'hABC) == 16'h0ABC, "R10", "normal word",
        64'(fmt_word(2'b00, 12'hABC)), 64'h0ABC);
    chk(fmt_word(2'b11, 12'h123) == 16'h3123, "R10", "hi-z word",
        64'(fmt_word(2'b11, 12'h123)), 64'h3123);
    chk(fmt_word(2'b01, 12'hFFF) == 16'h1FFF, "R10", "1k word",
        64'(fmt_word(2'b01, 12'hFFF)), 64'h1FFF);
  endtask

  task automatic test_slow_divider;     // R6 above the floor
    run_frame({16'h0A5C, 16'h2F01, 16'h3800}, 8'd7, 7);
  endtask

  task automatic test_clamped_divider;  // R6 clamp to chained floor
    run_frame({16'hFFFF, 16'h0001, 16'h8000}, 8'd1, MINH);
    run_frame({16'h1234, 16'h5678, 16'h9ABC}, 8'd0, MINH);
  endtask

  task automatic test_back_to_back;     // R8 gap between consecutive frames
    run_frame({TOT{1'b1}}, 8'd5, MINH);
    run_frame({24{2'b10}}, 8'd5, MINH);
    run_frame('0, 8'd6, 6);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_helper();
    test_slow_divider();
    test_clamped_divider();
    test_back_to_back();
    summary();
    $finish;
  end

endmodule